// File: doc/BRIEF.md
# Event Frame Timestamp Capture Unit

This block records the value of a free-running time counter when a precision-time event frame passes the network port, once for the receive direction and once for the transmit direction. On the receive side a classifier looks at the header fields that an upstream parser extracts: ethertype, IP protocol, UDP source and destination ports, and the message type and version nibbles. From these fields and a programmable filter mode it decides whether the frame gets a timestamp. The transmit side captures only frames that the sender has marked for timestamping.

Each direction has one capture slot, which holds a 64-bit time and a valid flag. When a slot is filled it locks, and later frames pass through without touching it. Software reads the stored time as two 32-bit words, low word first. Reading the high word releases the lock. Read data comes back one cycle after the read strobe. Clearing a direction's enable also empties its slot.

Top module: `evt_tstamp_capture`

## Requirements
- R1: A receive start-of-frame that the filter accepts, arriving while the receive slot is empty and receive capture is enabled, stores the time input of that cycle. From the next cycle rx_valid reads 1.
- R2: While a slot's valid flag is set, further frames in that direction are not captured and the stored time does not change.
- R3: A read of a slot's high word (address 1 for receive, 3 for transmit) clears that slot's valid flag from the next cycle. A read of the low word leaves the flag set.
- R4: Read addresses are 0 receive low, 1 receive high, 2 transmit low, 3 transmit high. rd_data is registered: it takes the selected word on the cycle after rd_en and otherwise holds its value. After reset, both slots and rd_data are zero.
- R5: A frame counts as a layer-2 event frame when the layer-2 filter enable is set and its ethertype equals 0x88F7.
- R6: A frame counts as a UDP event frame when the IP protocol is 17 and the destination port is 319. When the source-port check is enabled, the source port must also be 319.
- R7: The filter mode code selects which frames are captured. 0 captures nothing. 1 captures UDP event frames with version 1 and message type 0. 2 captures UDP event frames with version 1 and message type 1. 3 captures any layer-2 or UDP event frame with version 2 and message type 0 to 3. 4 captures every frame. Codes 5 to 7 behave like 0.
- R8: A transmit start-of-frame with the mark bit set, arriving while the transmit slot is empty and transmit capture is enabled, stores the time and sets tx_valid. Unmarked frames are never captured.
- R9: While a direction's enable is low, its valid flag reads 0 from the next cycle and no capture takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_now | input | 64 | Current time counter value |
| rx_en | input | 1 | Receive capture enable |
| tx_en | input | 1 | Transmit capture enable |
| rx_mode | input | 3 | Receive filter mode code |
| l2_filt_en | input | 1 | Enables the layer-2 ethertype match |
| src_port_chk | input | 1 | Also requires the UDP source port to match |
| rx_sof | input | 1 | Receive start-of-frame strobe; the parsed fields are valid with it |
| rx_ethertype | input | 16 | Parsed ethertype |
| rx_ip_proto | input | 8 | Parsed IP protocol |
| rx_udp_src | input | 16 | Parsed UDP source port |
| rx_udp_dst | input | 16 | Parsed UDP destination port |
| rx_msg_type | input | 4 | Parsed message type |
| rx_version | input | 4 | Parsed protocol version |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| tx_mark | input | 1 | Transmit frame is marked for timestamping |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Registered read data |
| rx_valid | output | 1 | Receive slot holds a timestamp |
| tx_valid | output | 1 | Transmit slot holds a timestamp |

## Verification
A slot whose lock does not hold would show at the ports as a changed high or low word on the next read of a locked value, or as a valid flag that drops after a low-word read. Either shows up in the cycle after that read. A classifier fault shows as rx_valid rising, or failing to rise, one cycle after a start-of-frame strobe. The reference model compares both flags and rd_data on every clock, so a fault shows at most one cycle after the stimulus that reaches it.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [2:0] {
    FM_OFF     = 3'd0,
    FM_V1_SYNC = 3'd1,
    FM_V1_DREQ = 3'd2,
    FM_V2_EVT  = 3'd3,
    FM_ALL     = 3'd4
  } filt_mode_e;

  localparam int unsigned TIME_W = 64;
  localparam int unsigned WORD_W = 32;
endpackage

// File: rtl/tsc_rx_classifier.sv
module tsc_rx_classifier
  import tsc_pkg::*;
#(
  parameter logic [15:0] EVT_ETYPE = 16'h88F7,
  parameter logic [7:0]  UDP_PROTO = 8'd17,
  parameter logic [15:0] EVT_PORT  = 16'd319,
  parameter int unsigned EVT_MAX   = 3
) (
  input  logic [2:0]  mode,
  input  logic        l2_filt_en,
  input  logic        src_port_chk,
  input  logic [15:0] ethertype,
  input  logic [7:0]  ip_proto,
  input  logic [15:0] udp_src,
  input  logic [15:0] udp_dst,
  input  logic [3:0]  msg_type,
  input  logic [3:0]  version,
  output logic        accept
);
  logic l2_hit, udp_hit, v2_event;
  filt_mode_e m;

  always_comb begin
    m        = filt_mode_e'(mode);
    l2_hit   = l2_filt_en && (ethertype == EVT_ETYPE);
    udp_hit  = (ip_proto == UDP_PROTO) && (udp_dst == EVT_PORT) &&
               (!src_port_chk || (udp_src == EVT_PORT));
    v2_event = (version == 4'd2) && (32'(msg_type) <= EVT_MAX);
    case (m)
      FM_V1_SYNC: accept = udp_hit && (version == 4'd1) && (msg_type == 4'd0);
      FM_V1_DREQ: accept = udp_hit && (version == 4'd1) && (msg_type == 4'd1);
      FM_V2_EVT:  accept = (l2_hit || udp_hit) && v2_event;
      FM_ALL:     accept = 1'b1;
      default:    accept = 1'b0;
    endcase
  end
endmodule

// File: rtl/tsc_capture_slot.sv
module tsc_capture_slot #(
  parameter int unsigned TW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          take,
  input  logic          rel,
  input  logic [TW-1:0] tnow,
  output logic [TW-1:0] ts_q,
  output logic          valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ts_q    <= '0;
      valid_q <= 1'b0;
    end else if (!en) begin
      valid_q <= 1'b0;
    end else if (take && !valid_q) begin
      ts_q    <= tnow;
      valid_q <= 1'b1;
    end else if (rel) begin
      valid_q <= 1'b0;
    end
  end

  // R1
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    (en && take && !valid_q) |=> (valid_q && ts_q == $past(tnow)));
  // R2
  locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && en) |=> (ts_q == $past(ts_q)));
  // R3
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && rel) |=> !valid_q);
  // R9
  disable_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !valid_q);
endmodule

// File: rtl/evt_tstamp_capture.sv
module evt_tstamp_capture
  import tsc_pkg::*;
#(
  parameter int unsigned TW = TIME_W,
  parameter int unsigned RW = WORD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] time_now,
  input  logic          rx_en,
  input  logic          tx_en,
  input  logic [2:0]    rx_mode,
  input  logic          l2_filt_en,
  input  logic          src_port_chk,
  input  logic          rx_sof,
  input  logic [15:0]   rx_ethertype,
  input  logic [7:0]    rx_ip_proto,
  input  logic [15:0]   rx_udp_src,
  input  logic [15:0]   rx_udp_dst,
  input  logic [3:0]    rx_msg_type,
  input  logic [3:0]    rx_version,
  input  logic          tx_sof,
  input  logic          tx_mark,
  input  logic          rd_en,
  input  logic [1:0]    rd_addr,
  output logic [RW-1:0] rd_data,
  output logic          rx_valid,
  output logic          tx_valid
);
  localparam int unsigned NSLOT = 2;

  logic          rx_accept;
  logic [NSLOT-1:0]  s_en, s_take, s_rel, s_valid;
  logic [TW-1:0] s_ts [NSLOT];

  tsc_rx_classifier u_cls (
    .mode(rx_mode), .l2_filt_en(l2_filt_en), .src_port_chk(src_port_chk),
    .ethertype(rx_ethertype), .ip_proto(rx_ip_proto), .udp_src(rx_udp_src),
    .udp_dst(rx_udp_dst), .msg_type(rx_msg_type), .version(rx_version),
    .accept(rx_accept)
  );

  assign s_en   = {tx_en, rx_en};
  assign s_take = {tx_sof && tx_mark, rx_sof && rx_accept};

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign s_rel[g] = rd_en && (rd_addr == 2'(2*g + 1));
    tsc_capture_slot #(.TW(TW)) u_slot (
      .clk(clk), .rst(rst), .en(s_en[g]), .take(s_take[g]), .rel(s_rel[g]),
      .tnow(time_now), .ts_q(s_ts[g]), .valid_q(s_valid[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      if (rd_addr[0]) rd_data <= s_ts[rd_addr[1]][TW-1 -: RW];
      else            rd_data <= s_ts[rd_addr[1]][RW-1:0];
    end
  end

  assign rx_valid = s_valid[0];
  assign tx_valid = s_valid[1];

  // R7
  mode_off_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_mode == 3'd0 && !rx_valid) |=> !rx_valid);
  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/evt_tstamp_capture_tb.sv
module evt_tstamp_capture_tb;
  logic clk = 0;
  logic rst = 1;
  logic [63:0] time_now = 64'h0000_0001_FFFF_FF00;
  logic rx_en = 0, tx_en = 0, l2_filt_en = 0, src_port_chk = 0;
  logic [2:0] rx_mode = 0;
  logic rx_sof = 0, tx_sof = 0, tx_mark = 0, rd_en = 0;
  logic [15:0] rx_ethertype = 0, rx_udp_src = 0, rx_udp_dst = 0;
  logic [7:0] rx_ip_proto = 0;
  logic [3:0] rx_msg_type = 0, rx_version = 0;
  logic [1:0] rd_addr = 0;
  logic [31:0] rd_data;
  logic rx_valid, tx_valid;

  int errors = 0, checks = 0;
  bit done = 0;
  string cur_req = "R4";

  evt_tstamp_capture u_dut (.*);

  always #5 clk = ~clk;
  always @(negedge clk) time_now <= time_now + 64'd8;

  // reference model
  bit m_rxv = 0, m_txv = 0;
  logic [63:0] m_rxts = 0, m_txts = 0;
  logic [31:0] m_rd = 0;

  function automatic bit want(input logic [2:0] md, input logic [15:0] et,
      input logic [7:0] pr, input logic [15:0] sp, input logic [15:0] dp,
      input logic [3:0] mt, input logic [3:0] vr);
    bit l2 = l2_filt_en && et == 16'h88F7;
    bit ud = pr == 8'd17 && dp == 16'd319 && (!src_port_chk || sp == 16'd319);
    if (md == 1) return ud && vr == 1 && mt == 0;
    if (md == 2) return ud && vr == 1 && mt == 1;
    if (md == 3) return (l2 || ud) && vr == 2 && mt < 4;
    if (md == 4) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_rxv = 0; m_txv = 0; m_rxts = 0; m_txts = 0; m_rd = 0;
    end else begin
      if (rd_en)
        case (rd_addr)
          2'd0: m_rd = m_rxts[31:0];
          2'd1: m_rd = m_rxts[63:32];
          2'd2: m_rd = m_txts[31:0];
          default: m_rd = m_txts[63:32];
        endcase
      if (!rx_en) m_rxv = 0;
      else if (!m_rxv && rx_sof && want(rx_mode, rx_ethertype, rx_ip_proto,
               rx_udp_src, rx_udp_dst, rx_msg_type, rx_version)) begin
        m_rxv = 1; m_rxts = time_now;
      end else if (rd_en && rd_addr == 2'd1) m_rxv = 0;
      if (!tx_en) m_txv = 0;
      else if (!m_txv && tx_sof && tx_mark) begin
        m_txv = 1; m_txts = time_now;
      end else if (rd_en && rd_addr == 2'd3) m_txv = 0;
    end
  end

  always @(negedge clk) if (!rst && !done) begin
    checks++;
    if (rx_valid !== m_rxv || tx_valid !== m_txv || rd_data !== m_rd) begin
      errors++;
      $display("FAIL %s rx_valid/tx_valid/rd_data act=%0b/%0b/%h exp=%0b/%0b/%h",
               cur_req, rx_valid, tx_valid, rd_data, m_rxv, m_txv, m_rd);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rx_frame(input logic [15:0] et, input logic [7:0] pr,
      input logic [15:0] sp, input logic [15:0] dp, input logic [3:0] mt,
      input logic [3:0] vr);
    @(negedge clk);
    rx_sof = 1; rx_ethertype = et; rx_ip_proto = pr; rx_udp_src = sp;
    rx_udp_dst = dp; rx_msg_type = mt; rx_version = vr;
    @(negedge clk);
    rx_sof = 0;
    idle(2);
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic expect_flag(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s flag act=%0b exp=%0b", req, act, exp);
    end
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst = 0;
    cur_req = "R4";
    expect_flag("R4", rx_valid, 0);
    expect_flag("R4", tx_valid, 0);
    rx_en = 1; tx_en = 1; l2_filt_en = 1; rx_mode = 3;
    cur_req = "R5"; rx_frame(16'h88F7, 8'd0, 0, 0, 4'd0, 4'd2);
    expect_flag("R5", rx_valid, 1);
    cur_req = "R3"; rd(0); expect_flag("R3", rx_valid, 1);
    rd(1); idle(1); expect_flag("R3", rx_valid, 0);
    cur_req = "R2"; rx_frame(16'h88F7, 8'd0, 0, 0, 4'd1, 4'd2);
    rx_frame(16'h88F7, 8'd0, 0, 0, 4'd2, 4'd2);
    rd(0); rd(1);
    cur_req = "R6"; rx_frame(16'h0800, 8'd17, 16'd5, 16'd319, 4'd1, 4'd2);
    expect_flag("R6", rx_valid, 1); rd(1);
    rx_frame(16'h0800, 8'd17, 16'd5, 16'd320, 4'd1, 4'd2);
    rx_frame(16'h0800, 8'd6, 16'd5, 16'd319, 4'd1, 4'd2);
    expect_flag("R6", rx_valid, 0);
    src_port_chk = 1;
    rx_frame(16'h0800, 8'd17, 16'd1000, 16'd319, 4'd0, 4'd2);
    expect_flag("R6", rx_valid, 0);
    rx_frame(16'h0800, 8'd17, 16'd319, 16'd319, 4'd0, 4'd2);
    expect_flag("R6", rx_valid, 1); rd(0); rd(1);
    src_port_chk = 0;
    cur_req = "R7";
    rx_frame(16'h88F7, 8'd0, 0, 0, 4'd8, 4'd2); expect_flag("R7", rx_valid, 0);
    l2_filt_en = 0;
    rx_frame(16'h88F7, 8'd0, 0, 0, 4'd0, 4'd2); expect_flag("R5", rx_valid, 0);
    rx_mode = 1;
    rx_frame(16'h0800, 8'd17, 0, 16'd319, 4'd1, 4'd1); expect_flag("R7", rx_valid, 0);
    rx_frame(16'h0800, 8'd17, 0, 16'd319, 4'd0, 4'd1); expect_flag("R7", rx_valid, 1);
    rd(1);
    rx_mode = 2;
    rx_frame(16'h0800, 8'd17, 0, 16'd319, 4'd0, 4'd1); expect_flag("R7", rx_valid, 0);
    rx_frame(16'h0800, 8'd17, 0, 16'd319, 4'd1, 4'd1); expect_flag("R7", rx_valid, 1);
    rd(1);
    rx_mode = 0;
    rx_frame(16'h0800, 8'd17, 0, 16'd319, 4'd0, 4'd2); expect_flag("R7", rx_valid, 0);
    rx_mode = 6;
    rx_frame(16'h0800, 8'd17, 0, 16'd319, 4'd0, 4'd2); expect_flag("R7", rx_valid, 0);
    rx_mode = 4;
    rx_frame(16'h0800, 8'd6, 0, 16'd80, 4'd9, 4'd0); expect_flag("R7", rx_valid, 1);
    cur_req = "R1"; rd(0); rd(1);
    rx_frame(16'h1234, 8'd1, 0, 0, 0, 0); rd(0); rd(1);
    cur_req = "R8";
    @(negedge clk); tx_sof = 1; tx_mark = 0; @(negedge clk); tx_sof = 0;
    idle(1); expect_flag("R8", tx_valid, 0);
    @(negedge clk); tx_sof = 1; tx_mark = 1; @(negedge clk); tx_sof = 0;
    idle(3);
    @(negedge clk); tx_sof = 1; @(negedge clk); tx_sof = 0; tx_mark = 0;
    expect_flag("R8", tx_valid, 1);
    rd(2); rd(3); idle(1); expect_flag("R8", tx_valid, 0);
    cur_req = "R9";
    rx_frame(16'h1234, 8'd1, 0, 0, 0, 0); expect_flag("R9", rx_valid, 1);
    @(negedge clk); rx_en = 0; idle(1); expect_flag("R9", rx_valid, 0);
    rx_frame(16'h1234, 8'd1, 0, 0, 0, 0); expect_flag("R9", rx_valid, 0);
    rx_en = 1; idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule